// File: doc/BRIEF.md
# G.711 Companding Datapath

This block sits between the sample queues and the serializer of an audio serial port. On the transmit side it turns linear PCM words into 8-bit G.711 codes, µ-law or A-law. On the receive side it turns received 8-bit codes back into linear words. A 2-bit mode input chooses bypass, µ-law or A-law. A format input chooses whether negative linear values use one's complement or two's complement. Companding only takes effect while the protocol flag marks the generic time-slot protocol. In any other protocol, samples pass through unchanged.

Each direction has one register stage with a valid/ready handshake. A sample is accepted on a clock edge where `*_in_valid` and `*_in_ready` are both high. `*_in_ready` is high whenever the stage is empty or its output is being taken in the same cycle, so back-pressure from `*_out_ready` reaches the input in the same cycle. The control inputs are applied to a sample in the cycle it is accepted. The block also reports the effective data-size code, which is forced to the 8-bit code while companding is active.

Top module: `g711_compander`

## Requirements
- R1: The mode code selects processing as follows: 2'b00 and 2'b01 pass data through unchanged, 2'b10 selects µ-law and 2'b11 selects A-law. Companding applies only while `proto_tdm` is 1. When `proto_tdm` is 0, both directions pass data through unchanged in every mode.
- R2: µ-law compression reads the top 14 bits of the linear word as a signed value and clips its magnitude to 8158. It then adds 33, takes the segment s (0 to 7) as the leading-one position minus 5, and takes the mantissa as the 4 bits below the leading one. The code is the bitwise inverse of {negative, s[2:0], mantissa[3:0]}. It sits in the top 8 bits of the output word and the lower bits are zero.
- R3: A-law compression reads the top 13 bits of the linear word as a signed value and clips its magnitude m to 4095. The segment is 0 for m < 32, otherwise the leading-one position minus 4. The mantissa is m>>1 in segment 0 and m>>s otherwise, keeping 4 bits. The code is {positive, s[2:0], mantissa[3:0]} XOR 8'h55, MSB-aligned with the lower bits zero.
- R4: A linear input whose magnitude is beyond the supported range gives the largest code of its own sign. For µ-law that is 8'h80 for positive and 8'h00 for negative. For A-law it is 8'hAA for positive and 8'h2A for negative.
- R5: µ-law expansion reads the code from the top 8 bits of the received word and inverts it to get {negative, s, mantissa}. The magnitude is ((2·mantissa+33) << s) − 33, placed in the top 14 bits of the output word.
- R6: A-law expansion XORs the code with 8'h55 to get {positive, s, mantissa}. The magnitude is 2·mantissa+1 in segment 0, 2·mantissa+33 in segment 1, and (2·mantissa+33) << (s−1) above that, placed in the top 13 bits of the output word.
- R7: With `ones_cpl` = 1, a negative linear word is the bitwise inverse of its magnitude word; with 0 it is the two's complement negation. Expanding any code and compressing the result gives the same code back, except µ-law code 8'h7F in two's complement, which comes back as 8'hFF.
- R8: `dsize_eff` equals 3'b010 when `en` is 1, `proto_tdm` is 1 and the mode selects µ-law or A-law; otherwise it equals `dsize_cfg`.
- R9: In each direction, `*_in_ready` = !`*_out_valid` || `*_out_ready`. While the output is valid and not ready, it holds its data. Samples leave in the order they entered, none dropped and none repeated.
- R10: While `rst_n` is low, both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable, gates the data-size override |
| mode | input | 2 | Companding mode select |
| ones_cpl | input | 1 | 1: one's complement linear words, 0: two's complement |
| proto_tdm | input | 1 | 1 when the generic time-slot protocol is in use |
| dsize_cfg | input | 3 | Configured data-size code |
| dsize_eff | output | 3 | Effective data-size code |
| tx_in_valid | input | 1 | Transmit linear sample valid |
| tx_in_ready | output | 1 | Transmit stage can accept |
| tx_in_data | input | SAMPLE_W | Transmit linear sample |
| tx_out_valid | output | 1 | Processed transmit sample valid |
| tx_out_ready | input | 1 | Serializer takes the transmit sample |
| tx_out_data | output | SAMPLE_W | Code (MSB-aligned) or bypassed sample |
| rx_in_valid | input | 1 | Received word valid |
| rx_in_ready | output | 1 | Receive stage can accept |
| rx_in_data | input | SAMPLE_W | Received word, code in top 8 bits |
| rx_out_valid | output | 1 | Expanded sample valid |
| rx_out_ready | input | 1 | Consumer takes the expanded sample |
| rx_out_data | output | SAMPLE_W | Expanded linear sample or bypassed word |

## Verification
A wrong segment search or clip bound shows at the transmit output one cycle after acceptance, and only for inputs in the affected segment or range. That is why every linear input of a 14-bit build is swept under both laws and both formats. An expansion fault shows in the receive word in the same one-cycle window, and again when that word is compressed back to a different code. A stage whose valid or data goes wrong under back-pressure shows as a dropped, repeated or reordered sample in the next transfer. The irregular ready pattern in the bench exposes this within a few cycles.

// File: rtl/g711_pkg.sv
package g711_pkg;
  typedef enum logic [1:0] {
    CMP_OFF  = 2'b00,
    CMP_RSVD = 2'b01,
    CMP_MU   = 2'b10,
    CMP_A    = 2'b11
  } cmp_mode_e;

  localparam int CODE_W   = 8;
  localparam int MU_LIN_W = 14;
  localparam int A_LIN_W  = 13;
  localparam int MU_BIAS  = 33;
  localparam int MU_CLIP  = 8158;
  localparam int A_CLIP   = 4095;
  localparam logic [2:0] DSIZE_8BIT = 3'b010;
endpackage

// File: rtl/g711_compress.sv
module g711_compress
  import g711_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] lin,
  input  logic                law_a,
  input  logic                ones_cpl,
  output logic [CODE_W-1:0]   code
);
  localparam int MU_SH = SAMPLE_W - MU_LIN_W;
  localparam int A_SH  = SAMPLE_W - A_LIN_W;

  logic                neg;
  logic [SAMPLE_W-1:0] mag;
  logic [SAMPLE_W-1:0] mu_m;
  logic [SAMPLE_W-1:0] a_full;
  logic [13:0]         mu_b;
  logic [13:0]         mu_sh;
  logic [2:0]          mu_seg;
  logic [3:0]          mu_mant;
  logic [11:0]         a_m;
  logic [11:0]         a_sh;
  logic [2:0]          a_seg;
  logic [3:0]          a_mant;

  always_comb begin
    neg = lin[SAMPLE_W-1];
    if (!neg)          mag = lin;
    else if (ones_cpl) mag = ~lin;
    else               mag = ~lin + 1'b1;

    // mu-law: clip, bias, leading-one search
    mu_m = mag >> MU_SH;
    if (mu_m > SAMPLE_W'(MU_CLIP)) mu_m = SAMPLE_W'(MU_CLIP);
    mu_b = 14'(mu_m) + 14'(MU_BIAS);
    mu_seg = 3'd0;
    for (int i = 1; i < 8; i++) if (mu_b[5+i]) mu_seg = 3'(i);
    mu_sh   = mu_b >> ({1'b0, mu_seg} + 4'd1);
    mu_mant = mu_sh[3:0];

    // A-law: clip, leading-one search
    a_full = mag >> A_SH;
    if (a_full > SAMPLE_W'(A_CLIP)) a_full = SAMPLE_W'(A_CLIP);
    a_m = 12'(a_full);
    a_seg = 3'd0;
    for (int i = 1; i < 8; i++) if (a_m[4+i]) a_seg = 3'(i);
    a_sh   = a_m >> ((a_seg == 3'd0) ? 3'd1 : a_seg);
    a_mant = a_sh[3:0];

    if (law_a) code = {~neg, a_seg, a_mant} ^ 8'h55;
    else       code = ~{neg, mu_seg, mu_mant};
  end
endmodule

// File: rtl/g711_expand.sv
module g711_expand
  import g711_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [CODE_W-1:0]   code,
  input  logic                law_a,
  input  logic                ones_cpl,
  output logic [SAMPLE_W-1:0] lin
);
  localparam int MU_SH = SAMPLE_W - MU_LIN_W;
  localparam int A_SH  = SAMPLE_W - A_LIN_W;

  logic [7:0]          mu_u;
  logic [7:0]          a_x;
  logic [13:0]         mu_mag;
  logic [12:0]         a_base;
  logic [12:0]         a_mag;
  logic [SAMPLE_W-1:0] word;
  logic                neg;

  always_comb begin
    mu_u   = ~code;
    mu_mag = ((14'({mu_u[3:0], 1'b1}) + 14'd32) << mu_u[6:4]) - 14'(MU_BIAS);

    a_x    = code ^ 8'h55;
    a_base = 13'({a_x[3:0], 1'b1}) + ((a_x[6:4] != 3'd0) ? 13'd32 : 13'd0);
    a_mag  = (a_x[6:4] > 3'd1) ? (a_base << (a_x[6:4] - 3'd1)) : a_base;

    if (law_a) begin
      word = SAMPLE_W'(a_mag) << A_SH;
      neg  = ~a_x[7];
    end else begin
      word = SAMPLE_W'(mu_mag) << MU_SH;
      neg  = mu_u[7];
    end

    if (!neg)          lin = word;
    else if (ones_cpl) lin = ~word;
    else               lin = ~word + 1'b1;
  end
endmodule

// File: rtl/g711_stage.sv
module g711_stage #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R9

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data))); // R9
endmodule

// File: rtl/g711_compander.sv
module g711_compander
  import g711_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [1:0]          mode,
  input  logic                ones_cpl,
  input  logic                proto_tdm,
  input  logic [2:0]          dsize_cfg,
  output logic [2:0]          dsize_eff,
  input  logic                tx_in_valid,
  output logic                tx_in_ready,
  input  logic [SAMPLE_W-1:0] tx_in_data,
  output logic                tx_out_valid,
  input  logic                tx_out_ready,
  output logic [SAMPLE_W-1:0] tx_out_data,
  input  logic                rx_in_valid,
  output logic                rx_in_ready,
  input  logic [SAMPLE_W-1:0] rx_in_data,
  output logic                rx_out_valid,
  input  logic                rx_out_ready,
  output logic [SAMPLE_W-1:0] rx_out_data
);
  localparam int PAD_W = SAMPLE_W - CODE_W;

  cmp_mode_e           sel;
  logic                comp_on;
  logic                law_a;
  logic [CODE_W-1:0]   tx_code;
  logic [SAMPLE_W-1:0] rx_lin;
  logic [SAMPLE_W-1:0] tx_proc;
  logic [SAMPLE_W-1:0] rx_proc;

  assign sel     = cmp_mode_e'(mode);
  assign comp_on = proto_tdm && (sel == CMP_MU || sel == CMP_A);
  assign law_a   = (sel == CMP_A);

  assign dsize_eff = (en && comp_on) ? DSIZE_8BIT : dsize_cfg;

  g711_compress #(.SAMPLE_W(SAMPLE_W)) enc_i (
    .lin(tx_in_data), .law_a(law_a), .ones_cpl(ones_cpl), .code(tx_code));

  g711_expand #(.SAMPLE_W(SAMPLE_W)) dec_i (
    .code(rx_in_data[SAMPLE_W-1 -: CODE_W]), .law_a(law_a),
    .ones_cpl(ones_cpl), .lin(rx_lin));

  assign tx_proc = comp_on ? {tx_code, {PAD_W{1'b0}}} : tx_in_data;
  assign rx_proc = comp_on ? rx_lin : rx_in_data;

  g711_stage #(.SAMPLE_W(SAMPLE_W)) tx_stage_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_proc),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data));

  g711_stage #(.SAMPLE_W(SAMPLE_W)) rx_stage_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_proc),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data));

  AST_TX_POS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && comp_on && !tx_in_data[SAMPLE_W-1]) |-> tx_code[CODE_W-1]); // R2

  AST_RX_POS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && comp_on && rx_in_data[SAMPLE_W-1]) |-> !rx_lin[SAMPLE_W-1]); // R5

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && comp_on && $stable(mode) && $stable(proto_tdm) && $past(tx_in_valid && tx_in_ready))
      |-> (tx_out_data[PAD_W-1:0] == '0)); // R2
endmodule

// File: tb/g711_compander_tb_top.sv
`timescale 1ns/1ps
module g711_compander_tb_top;
  localparam int W = 14;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, en, ones_cpl, proto_tdm;
  logic [1:0] mode;
  logic [2:0] dsize_cfg, dsize_eff;
  logic tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
  logic rx_in_valid, rx_in_ready, rx_out_valid, rx_out_ready;
  logic [W-1:0] tx_in_data, tx_out_data, rx_in_data, rx_out_data;

  g711_compander #(.SAMPLE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .ones_cpl(ones_cpl),
    .proto_tdm(proto_tdm), .dsize_cfg(dsize_cfg), .dsize_eff(dsize_eff),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data));

  int n_vec = 0;
  int n_bad = 0;
  int stim [16384];
  int expv [16384];
  int got  [16384];

  task automatic check(string req, int act, int exp_v);
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic int to_signed(int raw);
    return (raw >= 8192) ? raw - 16384 : raw;
  endfunction

  function automatic int ref_comp(int raw, bit law, bit ones);
    int x = to_signed(raw);
    bit neg = (x < 0);
    int mag = !neg ? x : (ones ? -x - 1 : -x);
    int s = 0;
    int m;
    if (!law) begin
      m = (mag > 8158) ? 8158 : mag;
      m = m + 33;
      while (m >= (64 << s)) s++;
      return 255 - ((neg ? 128 : 0) + s * 16 + ((m >> (s + 1)) & 15));
    end
    m = mag >> 1;
    if (m > 4095) m = 4095;
    while (m >= (32 << s)) s++;
    return ((neg ? 0 : 128) + s * 16 + ((m >> ((s == 0) ? 1 : s)) & 15)) ^ 8'h55;
  endfunction

  function automatic int ref_exp(int c, bit law, bit ones);
    int u, seg, mant, mag;
    bit neg;
    if (!law) begin
      u = 255 - c; neg = (u >= 128); seg = (u >> 4) & 7; mant = u & 15;
      mag = ((2 * mant + 33) << seg) - 33;
    end else begin
      u = c ^ 8'h55; neg = (u < 128); seg = (u >> 4) & 7; mant = u & 15;
      mag = (seg == 0) ? 2 * mant + 1 : (2 * mant + 33) << (seg - 1);
      mag = mag * 2;
    end
    if (!neg) return mag;
    return ones ? (~mag) & 16383 : (-mag) & 16383;
  endfunction

  task automatic run_dir(bit is_rx, int n, bit bp, string req);
    int si = 0;
    int oi = 0;
    int cyc = 0;
    while (oi < n) begin
      @(negedge clk);
      cyc++;
      if (is_rx) begin
        rx_out_ready = bp ? ((cyc % 3) != 0) : 1'b1;
        rx_in_valid  = (si < n);
        rx_in_data   = W'(stim[(si < n) ? si : 0]);
      end else begin
        tx_out_ready = bp ? ((cyc % 4) != 1) : 1'b1;
        tx_in_valid  = (si < n);
        tx_in_data   = W'(stim[(si < n) ? si : 0]);
      end
      #0.5;
      if (is_rx) begin
        if (rx_out_valid && rx_out_ready) begin
          check(req, int'(rx_out_data), expv[oi]); got[oi] = int'(rx_out_data); oi++;
        end
        if (rx_in_valid && rx_in_ready) si++;
      end else begin
        if (tx_out_valid && tx_out_ready) begin
          check(req, int'(tx_out_data), expv[oi]); got[oi] = int'(tx_out_data); oi++;
        end
        if (tx_in_valid && tx_in_ready) si++;
      end
    end
    @(negedge clk);
    tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    #0.5;
    check(req, int'(is_rx ? rx_out_valid : tx_out_valid), 0);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_vec, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; ones_cpl = 1'b0; proto_tdm = 1'b1; mode = 2'b00;
    dsize_cfg = 3'b100; tx_in_valid = 1'b1; rx_in_valid = 1'b1;
    tx_in_data = '0; rx_in_data = '0; tx_out_ready = 1'b0; rx_out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", int'(tx_out_valid), 0);
    check("R10", int'(rx_out_valid), 0);
    tx_in_valid = 1'b0; rx_in_valid = 1'b0; tx_out_ready = 1'b1; rx_out_ready = 1'b1;
    @(negedge clk); rst_n = 1'b1;

    // R8 data-size override
    mode = 2'b10; #0.5; check("R8", int'(dsize_eff), 2);
    mode = 2'b11; #0.5; check("R8", int'(dsize_eff), 2);
    mode = 2'b01; #0.5; check("R8", int'(dsize_eff), 4);
    mode = 2'b00; #0.5; check("R8", int'(dsize_eff), 4);
    mode = 2'b10; en = 1'b0; #0.5; check("R8", int'(dsize_eff), 4);
    en = 1'b1; proto_tdm = 1'b0; #0.5; check("R8", int'(dsize_eff), 4);
    proto_tdm = 1'b1;

    // R2 / R3: every linear input, both laws, both formats
    for (int f = 0; f < 2; f++) begin
      for (int l = 0; l < 2; l++) begin
        ones_cpl = f[0]; mode = l[0] ? 2'b11 : 2'b10;
        for (int i = 0; i < 16384; i++) begin
          stim[i] = i; expv[i] = ref_comp(i, l[0], f[0]) << 6;
        end
        run_dir(1'b0, 16384, 1'b0, l[0] ? "R3" : "R2");
      end
    end

    // R4 saturation corners
    ones_cpl = 1'b0; mode = 2'b10;
    stim[0] = 8191; expv[0] = 8'h80 << 6;
    stim[1] = 8192; expv[1] = 8'h00 << 6;
    stim[2] = 8170; expv[2] = 8'h80 << 6;
    run_dir(1'b0, 3, 1'b0, "R4");
    ones_cpl = 1'b1; mode = 2'b11;
    stim[0] = 8191; expv[0] = 8'hAA << 6;
    stim[1] = 8192; expv[1] = 8'h2A << 6;
    run_dir(1'b0, 2, 1'b0, "R4");

    // R5 / R6 expansion, then R7 round trip
    for (int f = 0; f < 2; f++) begin
      for (int l = 0; l < 2; l++) begin
        ones_cpl = f[0]; mode = l[0] ? 2'b11 : 2'b10;
        for (int c = 0; c < 256; c++) begin
          stim[c] = c << 6; expv[c] = ref_exp(c, l[0], f[0]);
        end
        run_dir(1'b1, 256, 1'b0, l[0] ? "R6" : "R5");
        for (int c = 0; c < 256; c++) begin
          stim[c] = got[c];
          expv[c] = ((!l[0] && !f[0] && c == 8'h7F) ? 8'hFF : c) << 6;
        end
        run_dir(1'b0, 256, 1'b0, "R7");
      end
    end

    // R1 bypass modes and non-TDM protocol
    for (int k = 0; k < 3; k++) begin
      mode = (k == 0) ? 2'b00 : ((k == 1) ? 2'b01 : 2'b11);
      proto_tdm = (k != 2);
      for (int i = 0; i < 20; i++) begin
        stim[i] = (i * 1237 + 91) & 16383; expv[i] = stim[i];
      end
      run_dir(1'b0, 20, 1'b0, "R1");
      run_dir(1'b1, 20, 1'b0, "R1");
    end

    // R9 ordering under back-pressure, with companding active
    proto_tdm = 1'b1; mode = 2'b10; ones_cpl = 1'b0;
    for (int i = 0; i < 60; i++) begin
      stim[i] = (i * 2711 + 5) & 16383; expv[i] = ref_comp(stim[i], 1'b0, 1'b0) << 6;
    end
    run_dir(1'b0, 60, 1'b1, "R9");
    mode = 2'b00;
    for (int i = 0; i < 60; i++) begin
      stim[i] = (i * 977 + 13) & 16383; expv[i] = stim[i];
    end
    run_dir(1'b1, 60, 1'b1, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule